// File: doc/BRIEF.md
# Squaring G-Function Next-State Core

This block holds the eight-word state of a coupled-map keystream generator and advances it by one round per strobe. For every index the state word is added to the counter of the same index, modulo 2^32. The sum is squared to a full 64-bit product. The upper and lower halves of that product are then combined with XOR into one 32-bit g value.

A ring of eight mixing cells forms each new state word. A cell adds its own g value to rotated copies of the two g values just before it in the ring. Even and odd cells use different rotation amounts.

Software or a controller writes the initial state through the load port. It presents freshly updated counters on every round and pulses the step strobe. The counter update and the keystream extraction sit outside this block.

Top module: `chaos_state_core`

## Requirements
- R1: While rst_ni is low, all eight state words read zero on state_o.
- R2: When load_i is high at a clock edge, state_o holds load_state_i after that edge (word i at bits [32i+31:32i]), and no update takes place, even if step_i is also high.
- R3: When load_i and step_i are both low at a clock edge, state_o does not change.
- R4: For each index i, g[i] is formed from s = (x[i] + c[i]) mod 2^32 as the low 32 bits of s*s XOR the high 32 bits of s*s. Counter i is read from ctr_i bits [32i+31:32i].
- R5: For even j, the new x[j] is g[j] + rotl16(g[j-1]) + rotl16(g[j-2]) mod 2^32, with indices taken modulo 8.
- R6: For odd j, the new x[j] is g[j] + rotl8(g[j-1]) + g[j-2] mod 2^32, with indices taken modulo 8.
- R7: On a step edge with load_i low, all eight words update together. The g values come from the state registered before the edge and the ctr_i value present at that edge. The result is visible one edge after the strobe.
- R8: The sum x[i]+c[i] wraps before squaring. For example, x = FFFFFFFF and c = 1 give g = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write load_state_i into the state |
| load_state_i | input | 256 | Eight packed state words for loading |
| step_i | input | 1 | Advance the state by one round |
| ctr_i | input | 256 | Eight packed counter words for this round |
| state_o | output | 256 | Eight packed registered state words |

## Verification
Three behaviours are checked by the assertions on every cycle. A load edge leaves the loaded value in the state. An edge with neither load nor step leaves the state unchanged. A step edge stores the output of the mixing ring. Inside the squaring and mixing logic, immediate checks cover simple fixed points of the arithmetic.

The arithmetic itself can only be shown by the bench's scenarios, run against an independent model. This covers the folded square, the two rotation patterns, the index wrap around the ring and the wrap of the sum before squaring. The bench runs long step sequences under varied counters and boundary values for this.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_N_WORDS = 8;
  localparam int unsigned DEF_ROT_EVN = 16;
  localparam int unsigned DEF_ROT_ODD = 8;
endpackage

// File: rtl/chaos_gfold.sv
module chaos_gfold #(
  parameter int unsigned WORD_W = chaos_pkg::DEF_WORD_W
) (
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] c_i,
  output logic [WORD_W-1:0] g_o
);
  localparam int unsigned SQ_W = 2 * WORD_W;

  logic [WORD_W-1:0] sum_w;
  logic [SQ_W-1:0]   sq_w;

  // sum wraps before squaring
  assign sum_w = x_i + c_i;
  assign sq_w  = {{WORD_W{1'b0}}, sum_w} * {{WORD_W{1'b0}}, sum_w};
  assign g_o   = sq_w[WORD_W-1:0] ^ sq_w[SQ_W-1:WORD_W];

  always_comb begin
    if (sum_w == WORD_W'(1)) AST_UNIT_SQUARE: assert (g_o == WORD_W'(1)); // R4
    if (sum_w == '0) AST_ZERO_SUM: assert (g_o == '0); // R8
  end
endmodule

// File: rtl/chaos_mix.sv
module chaos_mix #(
  parameter int unsigned WORD_W  = chaos_pkg::DEF_WORD_W,
  parameter int unsigned N_WORDS = chaos_pkg::DEF_N_WORDS,
  parameter int unsigned ROT_EVN = chaos_pkg::DEF_ROT_EVN,
  parameter int unsigned ROT_ODD = chaos_pkg::DEF_ROT_ODD
) (
  input  logic [N_WORDS*WORD_W-1:0] g_i,
  output logic [N_WORDS*WORD_W-1:0] x_o
);
  localparam int unsigned VEC_W = N_WORDS * WORD_W;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int unsigned r);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} << (r % WORD_W);
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  for (genvar j = 0; j < N_WORDS; j++) begin : g_cell
    localparam int unsigned J1 = (j + N_WORDS - 1) % N_WORDS;
    localparam int unsigned J2 = (j + N_WORDS - 2) % N_WORDS;
    logic [WORD_W-1:0] g0, g1, g2;
    assign g0 = g_i[j*WORD_W +: WORD_W];
    assign g1 = g_i[J1*WORD_W +: WORD_W];
    assign g2 = g_i[J2*WORD_W +: WORD_W];
    if ((j % 2) == 0) begin : g_even
      assign x_o[j*WORD_W +: WORD_W] = g0 + rotl(g1, ROT_EVN) + rotl(g2, ROT_EVN);
    end else begin : g_odd
      assign x_o[j*WORD_W +: WORD_W] = g0 + rotl(g1, ROT_ODD) + g2;
    end
  end

  always_comb begin
    if (g_i == VEC_W'(0)) AST_ZERO_RING: assert (x_o == VEC_W'(0)); // R5
  end
endmodule

// File: rtl/chaos_state_core.sv
module chaos_state_core #(
  parameter int unsigned WORD_W  = chaos_pkg::DEF_WORD_W,
  parameter int unsigned N_WORDS = chaos_pkg::DEF_N_WORDS,
  parameter int unsigned ROT_EVN = chaos_pkg::DEF_ROT_EVN,
  parameter int unsigned ROT_ODD = chaos_pkg::DEF_ROT_ODD
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [N_WORDS*WORD_W-1:0]   load_state_i,
  input  logic                        step_i,
  input  logic [N_WORDS*WORD_W-1:0]   ctr_i,
  output logic [N_WORDS*WORD_W-1:0]   state_o
);
  localparam int unsigned VEC_W = N_WORDS * WORD_W;

  logic [VEC_W-1:0] state_q;
  logic [VEC_W-1:0] g_w;
  logic [VEC_W-1:0] mix_w;

  for (genvar i = 0; i < N_WORDS; i++) begin : g_fold
    chaos_gfold #(.WORD_W(WORD_W)) u_fold (
      .x_i (state_q[i*WORD_W +: WORD_W]),
      .c_i (ctr_i[i*WORD_W +: WORD_W]),
      .g_o (g_w[i*WORD_W +: WORD_W])
    );
  end

  chaos_mix #(
    .WORD_W (WORD_W),
    .N_WORDS(N_WORDS),
    .ROT_EVN(ROT_EVN),
    .ROT_ODD(ROT_ODD)
  ) u_mix (
    .g_i (g_w),
    .x_o (mix_w)
  );

  // load has priority over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '0;
    else if (load_i)  state_q <= load_state_i;
    else if (step_i)  state_q <= mix_w;
  end

  assign state_o = state_q;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_o == $past(load_state_i)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(state_o)); // R3
  AST_STEP_TAKES_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> state_o == $past(mix_w)); // R7
endmodule

// File: tb/chaos_state_core_test.sv
module chaos_state_core_test;
  localparam int W = 32;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic step_i = 1'b0;
  logic [N*W-1:0] load_state_i = '0;
  logic [N*W-1:0] ctr_i = '0;
  logic [N*W-1:0] state_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [W-1:0] mx [N];
  logic [31:0] seed = 32'h1234_5678;

  chaos_state_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_state_i(load_state_i),
    .step_i(step_i), .ctr_i(ctr_i), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc >= WDOG_LIMIT) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", cyc, WDOG_LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [W-1:0] rl(input logic [W-1:0] v, input int r);
    return (v << r) | (v >> (W - r));
  endfunction

  function automatic logic [W-1:0] gf(input logic [W-1:0] x, input logic [W-1:0] c);
    logic [W-1:0] s;
    logic [63:0] sq;
    s = x + c;
    sq = 64'(s) * 64'(s);
    return sq[31:0] ^ sq[63:32];
  endfunction

  function automatic logic [31:0] lcg(input logic [31:0] v);
    return v * 32'd1664525 + 32'd1013904223;
  endfunction

  // independent model of one round
  task automatic model_step(input logic [N*W-1:0] c);
    logic [W-1:0] g [N];
    for (int i = 0; i < N; i++) g[i] = gf(mx[i], c[i*W +: W]);
    for (int j = 0; j < N; j++) begin
      if (j % 2 == 0) mx[j] = g[j] + rl(g[(j+7)%8], 16) + rl(g[(j+6)%8], 16);
      else            mx[j] = g[j] + rl(g[(j+7)%8], 8) + g[(j+6)%8];
    end
  endtask

  task automatic compare_state(input string tag);
    for (int i = 0; i < N; i++) begin
      checks = checks + 1;
      if (state_o[i*W +: W] !== mx[i]) begin
        fails = fails + 1;
        $display("FAIL %s word %0d: got %08h expected %08h", tag, i, state_o[i*W +: W], mx[i]);
      end
    end
  endtask

  task automatic cycle(input logic ld, input logic [N*W-1:0] ls, input logic st,
                       input logic [N*W-1:0] c);
    load_i = ld; load_state_i = ls; step_i = st; ctr_i = c;
    @(posedge clk_i);
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
  endtask

  task automatic do_load(input logic [N*W-1:0] ls, input logic st, input string tag);
    cycle(1'b1, ls, st, {N{32'hA5A5_5A5A}});
    for (int i = 0; i < N; i++) mx[i] = ls[i*W +: W];
    compare_state(tag);
  endtask

  task automatic do_step(input logic [N*W-1:0] c);
    cycle(1'b0, '0, 1'b1, c);
    model_step(c);
    compare_state("R4 R5 R6 R7 round");
  endtask

  function automatic logic [N*W-1:0] rand_vec();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) begin
      seed = lcg(seed);
      v[i*W +: W] = seed;
    end
    return v;
  endfunction

  initial begin
    logic [N*W-1:0] pat;
    logic [N*W-1:0] cv;
    for (int i = 0; i < N; i++) mx[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    compare_state("R1 reset");
    rst_ni = 1'b1;

    // R2: load with concurrent step, load wins
    for (int i = 0; i < N; i++) pat[i*W +: W] = 32'h0123_4567 + 32'h1111_1111 * i;
    do_load(pat, 1'b1, "R2 load over step");

    // R3: idle cycles hold
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, rand_vec(), 1'b0, rand_vec());
      compare_state("R3 idle hold");
    end

    // R4..R7: random counter rounds
    for (int k = 0; k < 60; k++) do_step(rand_vec());

    // R8: sum wraps to zero, all g zero
    do_load({N{32'hFFFF_FFFF}}, 1'b0, "R2 load ones");
    cycle(1'b0, '0, 1'b1, {N{32'h0000_0001}});
    for (int i = 0; i < N; i++) mx[i] = '0;
    compare_state("R8 wrap to zero");

    // R4: small squares from zero state, distinct per index
    for (int i = 0; i < N; i++) cv[i*W +: W] = 32'(i + 1);
    do_step(cv);

    // R4: sum with carry out above the square midpoint
    for (int i = 0; i < N; i++) cv[i*W +: W] = 32'h8000_0000 + 32'(i * 3);
    do_load('0, 1'b0, "R2 load zeros");
    do_step(cv);

    // stress: all-ones counters
    for (int i = 0; i < N; i++) pat[i*W +: W] = 32'h1 << (i * 4);
    do_load(pat, 1'b0, "R2 load walk");
    for (int k = 0; k < 40; k++) do_step({N{32'hFFFF_FFFF}});

    // R2 again, after rounds
    do_load(rand_vec(), 1'b1, "R2 reload over step");
    for (int k = 0; k < 20; k++) do_step(rand_vec());
    cycle(1'b0, '0, 1'b0, rand_vec());
    compare_state("R3 idle after rounds");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule